// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block gathers five controller status conditions into one 8-bit status word and drives a single active-high interrupt line. A host-written mask selects which of these conditions can raise that line. Two of the sources are level-type: receive-inhibit and transmit-ready. These follow their live input every cycle. The other three are latched: the reconfiguration-timeout flag, the excessive-NAK flag and the next-ID-changed flag. The protocol engine sets each latched flag with a one-cycle pulse, and the flag holds until the host writes the clear command that owns it.

The host reaches the block through a plain write port. It writes the mask at address 0 and a command byte at address 1. A status bit and its mask bit sit at the same bit position. The interrupt output is registered. It asserts in the cycle after a masked product becomes true.

There is no streaming data path. Every pin is a plain control or status signal, and the write port has no back-pressure.

Top module: `sirq_ctrl`

## Requirements
- R1: After reset, `irq_o` is 0, every latched flag is 0 and the mask is 0. No interrupt can assert until the host writes the mask.
- R2: A write to address 0 loads the mask. The enabling bits are at these positions: bit 7 receive-inhibit, bit 4 next-ID-changed, bit 3 excessive-NAK, bit 2 reconfiguration-timeout, bit 0 transmit-ready. The mask forces bits 6, 5 and 1 to 0. A 1 enables that source.
- R3: `irq_o` is the registered OR of every (status bit AND mask bit) product, one clock after those values hold.
- R4: `status_o` carries receive-inhibit at bit 7, next-ID-changed at bit 4, excessive-NAK at bit 3, reconfiguration-timeout at bit 2 and transmit-ready at bit 0. Bits 6, 5 and 1 are always 0, so no other condition can reach the interrupt.
- R5: The level sources follow their inputs. Clearing their mask bit only hides the interrupt. Setting the mask bit again brings the interrupt back if the input is still 1.
- R6: A one-cycle set pulse makes its latched flag 1 at the next clock edge. The flag then stays 1 until its clear command arrives.
- R7: Command 8'h1E at address 1 clears the reconfiguration-timeout and next-ID-changed flags and leaves excessive-NAK set.
- R8: Command 8'h0E at address 1 clears only the excessive-NAK flag.
- R9: Any other command value, and a write to any address other than 0 or 1, leaves the flags and the mask unchanged.
- R10: When a set pulse and the clear command for the same flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Host write address (0 mask, 1 command) |
| wr_data | input | 8 | Host write data |
| rx_inhibit_i | input | 1 | Live receive-inhibit condition |
| tx_ready_i | input | 1 | Live transmit-ready condition |
| recon_pulse_i | input | 1 | Sets the reconfiguration-timeout flag |
| excnak_pulse_i | input | 1 | Sets the excessive-NAK flag |
| nextid_pulse_i | input | 1 | Sets the next-ID-changed flag |
| status_o | output | 8 | Status word (positions as in R4) |
| irq_o | output | 1 | Registered interrupt, active high |

## Verification
A latched flag can receive its set pulse and its clear command in the same cycle. A mask write can also land in the same cycle as set pulses. The bench drives a set pulse together with the matching clear command and requires the flag to read 1 afterwards. It also checks that a flag with no pulse in that cycle is cleared, and that the command leaves the other flag alone. The sweep writes every mask value in the same cycle as every pattern of the five sources. It then judges `status_o` and, one clock later, `irq_o` against values computed from the bit positions.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int N_LATCH = 3;

  // status / mask bit positions
  localparam int POS_RXINH  = 7;
  localparam int POS_NEXTID = 4;
  localparam int POS_EXCNAK = 3;
  localparam int POS_RECON  = 2;
  localparam int POS_TXRDY  = 0;

  localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(1);

  localparam logic [DATA_W-1:0] CMD_CLR_FLAGS = 8'h1E;
  localparam logic [DATA_W-1:0] CMD_POR_CLR   = 8'h0E;

  // latched flag index -> status position and clearing command
  localparam int LATCH_POS [N_LATCH] = '{POS_RECON, POS_EXCNAK, POS_NEXTID};
  localparam logic [DATA_W-1:0] LATCH_CLR [N_LATCH] =
    '{CMD_CLR_FLAGS, CMD_POR_CLR, CMD_CLR_FLAGS};

  localparam logic [DATA_W-1:0] MASK_VALID =
    DATA_W'((1 << POS_RXINH) | (1 << POS_NEXTID) | (1 << POS_EXCNAK) |
            (1 << POS_RECON) | (1 << POS_TXRDY));
endpackage

// File: rtl/sirq_mask_reg.sv
module sirq_mask_reg
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)    mask <= '0;
    else if (load) mask <= din & MASK_VALID;
  end
endmodule

// File: rtl/sirq_cmd_decode.sv
module sirq_cmd_decode
  import sirq_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mask_load,
  output logic [N_LATCH-1:0] clr
);
  logic cmd_wr;
  assign mask_load = wr_en && (wr_addr == ADDR_MASK);
  assign cmd_wr    = wr_en && (wr_addr == ADDR_CMD);

  for (genvar i = 0; i < N_LATCH; i++) begin : g_clr
    assign clr[i] = cmd_wr && (wr_data == LATCH_CLR[i]);
  end
endmodule

// File: rtl/sirq_flag_bank.sv
module sirq_flag_bank
  import sirq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LATCH-1:0] set,
  input  logic [N_LATCH-1:0] clr,
  output logic [N_LATCH-1:0] flag
);
  for (genvar i = 0; i < N_LATCH; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flag[i] <= 1'b0;
      else if (set[i]) flag[i] <= 1'b1;   // set dominates clear
      else if (clr[i]) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sirq_combine.sv
module sirq_combine
  import sirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] status,
  input  logic [DATA_W-1:0] mask,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(status & mask);
  end
endmodule

// File: rtl/sirq_ctrl.sv
module sirq_ctrl
  import sirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        rx_inhibit_i,
  input  logic        tx_ready_i,
  input  logic        recon_pulse_i,
  input  logic        excnak_pulse_i,
  input  logic        nextid_pulse_i,
  output logic [7:0]  status_o,
  output logic        irq_o
);
  logic               mask_load;
  logic [N_LATCH-1:0] clr, set, flag;
  logic [DATA_W-1:0]  mask_q;
  logic [DATA_W-1:0]  status;

  sirq_cmd_decode u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mask_load(mask_load), .clr(clr)
  );

  sirq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .load(mask_load), .din(wr_data), .mask(mask_q)
  );

  assign set = {nextid_pulse_i, excnak_pulse_i, recon_pulse_i};

  sirq_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set(set), .clr(clr), .flag(flag)
  );

  always_comb begin
    status = '0;
    status[POS_RXINH] = rx_inhibit_i;
    status[POS_TXRDY] = tx_ready_i;
    for (int i = 0; i < N_LATCH; i++) status[LATCH_POS[i]] = flag[i];
  end

  sirq_combine u_irq (
    .clk(clk), .rst_n(rst_n), .status(status), .mask(mask_q), .irq(irq_o)
  );

  assign status_o = status;
endmodule

// File: rtl/sirq_ctrl_chk.sv
module sirq_ctrl_chk
  import sirq_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        recon_pulse_i,
  input logic        excnak_pulse_i,
  input logic [7:0]  status_o,
  input logic [7:0]  mask,
  input logic        irq_o
);
  logic cmd_cf, cmd_por;
  assign cmd_cf  = wr_en && wr_addr == 3'd1 && wr_data == 8'h1E;
  assign cmd_por = wr_en && wr_addr == 3'd1 && wr_data == 8'h0E;

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(status_o & mask))); // R3
  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 8'h00 |=> !irq_o); // R1
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd0) |=> mask == ($past(wr_data) & 8'h9D)); // R2
  AST_RSVD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & 8'h62) == 8'h00); // R4
  AST_SET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    recon_pulse_i |=> status_o[2]); // R6 R10
  AST_EXC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3] && !cmd_por) |=> status_o[3]); // R7
  AST_CF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_cf && !recon_pulse_i) |=> !status_o[2]); // R7
  AST_POR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_por && !excnak_pulse_i) |=> !status_o[3]); // R8
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == 3'd0) |=> $stable(mask)); // R9
endmodule

bind sirq_ctrl sirq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .recon_pulse_i(recon_pulse_i),
  .excnak_pulse_i(excnak_pulse_i), .status_o(status_o), .mask(mask_q),
  .irq_o(irq_o)
);

// File: tb/tb_sirq_ctrl.sv
module tb_sirq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic rx_inh = 1'b0, tx_rdy = 1'b0;
  logic p_recon = 1'b0, p_exc = 1'b0, p_nid = 1'b0;
  logic [7:0] status_o;
  logic irq_o;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;   // 50 MHz

  sirq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rx_inhibit_i(rx_inh), .tx_ready_i(tx_rdy),
    .recon_pulse_i(p_recon), .excnak_pulse_i(p_exc),
    .nextid_pulse_i(p_nid), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  function automatic logic [7:0] exp_status(logic [4:0] p);
    // p0 recon(bit2) p1 excnak(bit3) p2 nextid(bit4) p3 txrdy(bit0) p4 rxinh(bit7)
    return {p[4], 2'b00, p[2], p[1], p[0], 1'b0, p[3]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 status", status_o, 8'h00);
    check("R1 irq", {7'b0, irq_o}, 8'h00);
    // R1 no irq with zero mask while everything is active
    rx_inh = 1; tx_rdy = 1; p_recon = 1; p_exc = 1; p_nid = 1;
    cyc();
    p_recon = 0; p_exc = 0; p_nid = 0;
    cyc(); cyc();
    check("R1 unmasked irq", {7'b0, irq_o}, 8'h00);
    check("R4 status all", status_o, 8'h9D);
    // R6 hold over several cycles
    repeat (5) cyc();
    check("R6 hold", status_o & 8'h1C, 8'h1C);
    // R9 non-matching command and wrong address
    wr(3'd1, 8'h1F); wr(3'd2, 8'h1E); wr(3'd5, 8'h0E);
    check("R9 flags kept", status_o, 8'h9D);
    check("R9 mask kept", {7'b0, irq_o}, 8'h00);
    // R7 clear flags
    wr(3'd1, 8'h1E);
    check("R7 clear flags", status_o, 8'h89);
    // R8 POR clear
    wr(3'd1, 8'h0E);
    check("R8 por clear", status_o, 8'h81);
    // R8 POR clear does not touch recon/nextid
    p_recon = 1; p_nid = 1; cyc(); p_recon = 0; p_nid = 0;
    wr(3'd1, 8'h0E);
    check("R8 others kept", status_o, 8'h95);
    wr(3'd1, 8'h1E);
    // R5 level source masking
    rx_inh = 1; tx_rdy = 0;
    wr(3'd0, 8'h80); cyc();
    check("R5 ri unmasked", {7'b0, irq_o}, 8'h01);
    wr(3'd0, 8'h00); cyc();
    check("R5 ri hidden", {7'b0, irq_o}, 8'h00);
    wr(3'd0, 8'h80); cyc();
    check("R5 ri returns", {7'b0, irq_o}, 8'h01);
    rx_inh = 0; cyc(); cyc();
    check("R5 ri follows input", {7'b0, irq_o}, 8'h00);
    // R10 set and clear in same cycle
    p_exc = 1; cyc(); p_exc = 0;
    p_recon = 1; p_exc = 1;
    wr_en = 1; wr_addr = 3'd1; wr_data = 8'h1E; cyc();
    wr_en = 0; p_recon = 0; p_exc = 0;
    check("R10 set wins recon", status_o & 8'h0C, 8'h0C);
    p_exc = 1; wr_en = 1; wr_addr = 3'd1; wr_data = 8'h0E; cyc();
    wr_en = 0; p_exc = 0;
    check("R10 set wins excnak", status_o & 8'h0C, 8'h0C);
    // R2 R3 R4 exhaustive sweep: every mask x every source pattern
    for (int m = 0; m < 256; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic [7:0] es;
        wr(3'd1, 8'h1E); wr(3'd1, 8'h0E);
        rx_inh = p[4]; tx_rdy = p[3];
        p_recon = p[0]; p_exc = p[1]; p_nid = p[2];
        wr_en = 1; wr_addr = 3'd0; wr_data = 8'(m);
        cyc();
        wr_en = 0; p_recon = 0; p_exc = 0; p_nid = 0;
        es = exp_status(5'(p));
        if (m == 255) check("R4 status", status_o, es);
        cyc();
        check("R2 R3 irq", {7'b0, irq_o},
              {7'b0, |(es & 8'(m) & 8'h9D)});
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule